// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Stopwatch

This block keeps the time of day as BCD digits: seconds, minutes, hours and a day-of-week count. Hours run in either a 24-hour or a 12-hour format; the 12-hour format adds an afternoon bit. A single alarm compares the seconds, minutes and hours, plus the afternoon bit in 12-hour format. When they match, it raises a write-1-to-clear flag one 256 Hz tick after the counters reach the alarm value. An interrupt output follows that flag while the alarm interrupt is enabled.

The block is clocked by the system clock and advanced by a one-cycle `tick_i` strobe at 256 Hz, taken from a 32768 Hz source. Every 256th tick produces a one-cycle busy window. The time counters step at the end of that window, and writes to the time digits arriving inside it are dropped. A separate stopwatch turns the binary tick rate into hundredths and tenths of a second. It uses a repeating 25-step pattern of 2- and 3-tick intervals, which gives exactly one hundred hundredth steps per 256 ticks.

Software reaches the block through a flat byte-wide register file. Map: 0 seconds, 1 minutes, 2 hours, 3 day, 4 control, 5 alarm seconds, 6 alarm minutes, 7 alarm hours, 8 stopwatch, 9 status.

Top module: `rtc_bcd_top`

## Requirements
- R1: After reset all time, alarm and stopwatch digits read 0, the control register reads 0 (24-hour format, stopwatch stopped, interrupt disabled), `busy_o` is 0 and `irq_o` is 0.
- R2: `busy_o` is 1 for exactly the one cycle after the cycle in which the 256th tick since the last second was sampled, and the seconds register advances at the end of that cycle.
- R3: A write to address 0 to 3 (time digits) is ignored when it is sampled in a busy cycle; outside busy it takes effect on that edge.
- R4: Seconds and minutes (bits 6:4 tens, bits 3:0 units) count 00 to 59 in BCD; 59 wraps to 00 and carries into the next field.
- R5: A seconds or minutes units digit above 9 becomes 0 on its next increment, and a tens digit above 5 becomes 0 (with carry) on the next carry into it.
- R6: In 24-hour format the hour register (bits 5:4 tens, bits 3:0 units) counts 00 to 23; 23 wraps to 00 and advances the day.
- R7: In 12-hour format (control bit 1 = 1) hours count 12, 01 .. 11; going from 11 to 12 toggles hour bit 6 (1 = afternoon), and the day advances only on the step from 11 afternoon to 12 morning.
- R8: The day register (bits 2:0) counts 0 to 6 and wraps from 6 to 0.
- R9: When seconds, minutes and hour digits equal the alarm registers after a time update (hour bit 6 compared only in 12-hour format), status bit 1 is set on the first tick that follows; a mismatch leaves it clear.
- R10: Writing 1 to status bit 1 clears the alarm flag, except that a flag set in the same cycle wins; `irq_o` is 1 only while the flag and control bit 2 are both 1.
- R11: After a stopwatch clear, n ticks with control bit 0 = 1 yield a hundredths count equal to the number of k >= 1 with floor(64k/25) <= n, modulo 100; the stopwatch register holds tenths in bits 7:4 and hundredths in bits 3:0.
- R12: The stopwatch shows 0x00 again after exactly 256 running ticks; it holds its value while control bit 0 is 0; writing 1 to control bit 3 clears it.
- R13: Read data appears on `rd_data_o` one cycle after `rd_addr_i`; control bit 3 always reads 0; status bit 0 mirrors busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe at 256 Hz |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | One-cycle window in which the time counters step |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
Two pairs of events are made to collide in one cycle. First, a seconds write is driven while `busy_o` is high. It is judged by reading back the incremented second rather than the written value. Second, a write-1-to-clear of the alarm flag is driven on the same cycle as the tick that sets the flag. It is judged by `irq_o` still being 1 afterwards. Expected stopwatch readings come from a floor-based count of the 2/3-tick step pattern computed in the bench.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  localparam int REG_AW = 4;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_SEC  = 4'd0;
  localparam logic [REG_AW-1:0] ADR_MIN  = 4'd1;
  localparam logic [REG_AW-1:0] ADR_HOUR = 4'd2;
  localparam logic [REG_AW-1:0] ADR_DAY  = 4'd3;
  localparam logic [REG_AW-1:0] ADR_CTRL = 4'd4;
  localparam logic [REG_AW-1:0] ADR_ASEC = 4'd5;
  localparam logic [REG_AW-1:0] ADR_AMIN = 4'd6;
  localparam logic [REG_AW-1:0] ADR_AHR  = 4'd7;
  localparam logic [REG_AW-1:0] ADR_SW   = 4'd8;
  localparam logic [REG_AW-1:0] ADR_STAT = 4'd9;

  typedef struct packed {
    logic [2:0] tens;
    logic [3:0] units;
  } bcd60_t;

  typedef struct packed {
    logic       pm;
    logic [1:0] tens;
    logic [3:0] units;
  } hour_t;

  typedef struct packed {
    logic   carry;
    bcd60_t val;
  } inc60_t;

  typedef struct packed {
    logic  carry;
    hour_t val;
  } hinc_t;

  // Modulo-60 BCD step; illegal digits fall back to 0 when they step.
  function automatic inc60_t bcd60_inc(bcd60_t v);
    inc60_t r;
    r.carry = 1'b0;
    r.val   = v;
    if (v.units >= 4'd9) begin
      r.val.units = 4'd0;
      if (v.tens >= 3'd5) begin
        r.val.tens = 3'd0;
        r.carry    = 1'b1;
      end else begin
        r.val.tens = v.tens + 3'd1;
      end
    end else begin
      r.val.units = v.units + 4'd1;
    end
    return r;
  endfunction

  // Hour step for both formats; carry marks the start of a new day.
  function automatic hinc_t hour_inc(hour_t h, logic fmt12);
    hinc_t r;
    r.carry = 1'b0;
    r.val   = h;
    if (!fmt12) begin
      if (h.tens > 2'd2 || (h.tens == 2'd2 && h.units >= 4'd3)) begin
        r.val.tens  = 2'd0;
        r.val.units = 4'd0;
        r.carry     = 1'b1;
      end else if (h.units >= 4'd9) begin
        r.val.tens  = h.tens + 2'd1;
        r.val.units = 4'd0;
      end else begin
        r.val.units = h.units + 4'd1;
      end
    end else begin
      if (h.tens == 2'd1 && h.units == 4'd1) begin
        r.val.units = 4'd2;
        r.val.pm    = ~h.pm;
        r.carry     = h.pm;
      end else if (h.tens > 2'd1 || (h.tens == 2'd1 && h.units >= 4'd2)) begin
        r.val.tens  = 2'd0;
        r.val.units = 4'd1;
      end else if (h.units >= 4'd9) begin
        r.val.tens  = 2'd1;
        r.val.units = 4'd0;
      end else begin
        r.val.units = h.units + 4'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_bcd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       fmt12,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic       wr_day,
  input  logic [6:0] wr_val,
  output bcd60_t     sec_o,
  output bcd60_t     min_o,
  output hour_t      hour_o,
  output logic [2:0] day_o,
  output logic       busy_o
);
  localparam int SUB_W = $clog2(TICKS_PER_SEC);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  logic [SUB_W-1:0] sub_q;
  logic             busy_q;
  bcd60_t           sec_q, min_q;
  hour_t            hour_q;
  logic [2:0]       day_q;

  inc60_t s_nx, m_nx;
  hinc_t  h_nx;
  logic [2:0] d_nx;

  always_comb begin
    s_nx = bcd60_inc(sec_q);
    m_nx = s_nx.carry ? bcd60_inc(min_q) : inc60_t'({1'b0, min_q});
    h_nx = m_nx.carry ? hour_inc(hour_q, fmt12) : hinc_t'({1'b0, hour_q});
    if (!h_nx.carry)          d_nx = day_q;
    else if (day_q >= 3'd6)   d_nx = 3'd0;
    else                      d_nx = day_q + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= tick && (sub_q == SUB_LAST);
      if (tick) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else if (busy_q) begin
      sec_q  <= s_nx.val;
      min_q  <= m_nx.val;
      hour_q <= h_nx.val;
      day_q  <= d_nx;
    end else begin
      if (wr_sec)  sec_q  <= bcd60_t'(wr_val);
      if (wr_min)  min_q  <= bcd60_t'(wr_val);
      if (wr_hour) hour_q <= hour_t'(wr_val);
      if (wr_day)  day_q  <= wr_val[2:0];
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign day_o  = day_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_bcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   fmt12,
  input  logic   busy,
  input  bcd60_t sec,
  input  bcd60_t min,
  input  hour_t  hour,
  input  bcd60_t a_sec,
  input  bcd60_t a_min,
  input  hour_t  a_hour,
  input  logic   clr,
  output logic   flag_o
);
  logic updated_q, pend_q, flag_q, match;

  assign match = (sec == a_sec) && (min == a_min) &&
                 (hour.tens == a_hour.tens) && (hour.units == a_hour.units) &&
                 (!fmt12 || (hour.pm == a_hour.pm));

  always_ff @(posedge clk) begin
    if (rst) begin
      updated_q <= 1'b0;
      pend_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      updated_q <= busy;
      if (updated_q && match)  pend_q <= 1'b1;
      else if (tick)           pend_q <= 1'b0;
      if (tick && pend_q)      flag_q <= 1'b1;
      else if (clr)            flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int STEPS      = 25,
  parameter int STEP_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       clr,
  output logic [7:0] digits_o
);
  localparam int K_W  = $clog2(STEPS);
  localparam int IN_W = $clog2(STEP_TICKS / STEPS + 2);
  localparam logic [K_W-1:0] K_LAST = K_W'(STEPS - 1);

  logic [K_W-1:0]  k_q;
  logic [IN_W-1:0] in_q;
  logic [3:0]      tenth_q, hund_q;

  function automatic logic [IN_W-1:0] step_len(logic [K_W-1:0] k);
    int kk;
    kk = int'(k);
    return IN_W'(((kk + 1) * STEP_TICKS) / STEPS - (kk * STEP_TICKS) / STEPS);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      k_q     <= '0;
      in_q    <= '0;
      tenth_q <= '0;
      hund_q  <= '0;
    end else if (run && tick) begin
      if (in_q + 1'b1 == step_len(k_q)) begin
        in_q <= '0;
        k_q  <= (k_q == K_LAST) ? '0 : k_q + 1'b1;
        if (hund_q >= 4'd9) begin
          hund_q  <= 4'd0;
          tenth_q <= (tenth_q >= 4'd9) ? 4'd0 : tenth_q + 4'd1;
        end else begin
          hund_q <= hund_q + 4'd1;
        end
      end else begin
        in_q <= in_q + 1'b1;
      end
    end
  end

  assign digits_o = {tenth_q, hund_q};
endmodule

// File: rtl/rtc_bcd_top.sv
module rtc_bcd_top
  import rtc_bcd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 256,
  parameter int SW_STEPS      = 25,
  parameter int SW_STEP_TICKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [REG_DW-1:0] rd_data_o,
  output logic              busy_o,
  output logic              irq_o
);
  bcd60_t sec_w, min_w, a_sec_q, a_min_q;
  hour_t  hour_w, a_hour_q;
  logic [2:0] day_w;
  logic [7:0] sw_w;
  logic sw_run_q, fmt12_q, ie_q, flag_w, busy_w;
  logic wr_sec_w, wr_min_w, wr_hour_w, wr_day_w, sw_clr_w, flag_clr_w;
  logic [REG_DW-1:0] rd_q;
  logic wr_unused;

  assign wr_unused  = wr_data_i[7];
  assign wr_sec_w   = wr_en_i && wr_addr_i == ADR_SEC;
  assign wr_min_w   = wr_en_i && wr_addr_i == ADR_MIN;
  assign wr_hour_w  = wr_en_i && wr_addr_i == ADR_HOUR;
  assign wr_day_w   = wr_en_i && wr_addr_i == ADR_DAY;
  assign sw_clr_w   = wr_en_i && wr_addr_i == ADR_CTRL && wr_data_i[3];
  assign flag_clr_w = wr_en_i && wr_addr_i == ADR_STAT && wr_data_i[1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sw_run_q <= 1'b0;
      fmt12_q  <= 1'b0;
      ie_q     <= 1'b0;
      a_sec_q  <= '0;
      a_min_q  <= '0;
      a_hour_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADR_CTRL: {ie_q, fmt12_q, sw_run_q} <= wr_data_i[2:0];
        ADR_ASEC: a_sec_q  <= bcd60_t'(wr_data_i[6:0]);
        ADR_AMIN: a_min_q  <= bcd60_t'(wr_data_i[6:0]);
        ADR_AHR:  a_hour_q <= hour_t'(wr_data_i[6:0]);
        default: ;
      endcase
    end
  end

  rtc_time_core #(.TICKS_PER_SEC(TICKS_PER_SEC)) time_i (
    .clk(clk_i), .rst(rst_i), .tick(tick_i), .fmt12(fmt12_q),
    .wr_sec(wr_sec_w), .wr_min(wr_min_w), .wr_hour(wr_hour_w), .wr_day(wr_day_w),
    .wr_val(wr_data_i[6:0]),
    .sec_o(sec_w), .min_o(min_w), .hour_o(hour_w), .day_o(day_w), .busy_o(busy_w)
  );

  rtc_alarm alarm_i (
    .clk(clk_i), .rst(rst_i), .tick(tick_i), .fmt12(fmt12_q), .busy(busy_w),
    .sec(sec_w), .min(min_w), .hour(hour_w),
    .a_sec(a_sec_q), .a_min(a_min_q), .a_hour(a_hour_q),
    .clr(flag_clr_w), .flag_o(flag_w)
  );

  rtc_stopwatch #(.STEPS(SW_STEPS), .STEP_TICKS(SW_STEP_TICKS)) sw_i (
    .clk(clk_i), .rst(rst_i), .tick(tick_i), .run(sw_run_q), .clr(sw_clr_w),
    .digits_o(sw_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q <= '0;
    end else begin
      case (rd_addr_i)
        ADR_SEC:  rd_q <= {1'b0, sec_w};
        ADR_MIN:  rd_q <= {1'b0, min_w};
        ADR_HOUR: rd_q <= {1'b0, hour_w};
        ADR_DAY:  rd_q <= {5'd0, day_w};
        ADR_CTRL: rd_q <= {5'd0, ie_q, fmt12_q, sw_run_q};
        ADR_ASEC: rd_q <= {1'b0, a_sec_q};
        ADR_AMIN: rd_q <= {1'b0, a_min_q};
        ADR_AHR:  rd_q <= {1'b0, a_hour_q};
        ADR_SW:   rd_q <= sw_w;
        ADR_STAT: rd_q <= {6'd0, flag_w, busy_w};
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign busy_o    = busy_w;
  assign irq_o     = flag_w && ie_q;
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       busy,
  input logic [6:0] sec,
  input logic [6:0] hour,
  input logic [2:0] day,
  input logic       wr_day,
  input logic       flag,
  input logic [7:0] sw,
  input logic       sw_run,
  input logic       sw_clr
);
  assert_busy_single_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  assert_busy_steps_sec_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> (sec != $past(sec)));

  assert_day_at_midnight_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_day) && day != $past(day)) |-> (hour[5:0] == 6'h00 || hour[5:0] == 6'h12));

  assert_flag_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick));

  assert_sw_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!sw_run && !sw_clr) |=> $stable(sw));
endmodule

bind rtc_bcd_top rtc_bcd_chk chk_i (
  .clk(clk_i), .rst(rst_i), .tick(tick_i), .busy(busy_o),
  .sec(sec_w), .hour(hour_w), .day(day_w), .wr_day(wr_day_w),
  .flag(flag_w), .sw(sw_w), .sw_run(sw_run_q), .sw_clr(sw_clr_w)
);

// File: tb/rtc_bcd_top_tb_top.sv
module rtc_bcd_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int sub_cnt  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  logic rd_v = 1'b0, rd_v_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_top dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .irq_o(irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_addr = a;
    rd_v    = 1'b1;
    @(negedge clk);
    rd_v    = 1'b0;
  endtask

  always @(posedge clk) rd_v_q <= rd_v;

  // monitor side of the scoreboard
  always @(negedge clk) begin : monitor
    item_t it;
    if (rd_v_q) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R13: actual read with no expectation expected queued item");
      end else begin
        it = sb_q.pop_front();
        check(rd_data, it.exp, it.tag);
      end
    end
  end

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    sub_cnt = (sub_cnt + n) % 256;
  endtask

  // returns in the busy cycle
  task automatic next_second();
    run_ticks(256 - sub_cnt);
  endtask

  // returns once the counters hold the new second
  task automatic second();
    next_second();
    @(negedge clk);
  endtask

  function automatic logic [7:0] sw_model(input int n);
    int c = 0;
    for (int k = 1; k <= 100; k++)
      if ((64 * k) / 25 <= (n % 256)) c++;
    c = c % 100;
    return {4'((c / 10) % 10), 4'(c % 10)};
  endfunction

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    do_write(4'd2, h);
    do_write(4'd1, m);
    do_write(4'd0, s);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check({7'd0, busy}, 8'h00, "R1 busy");
    check({7'd0, irq},  8'h00, "R1 irq");
    rd_expect(4'd0, 8'h00, "R1 sec");
    rd_expect(4'd2, 8'h00, "R1 hour");
    rd_expect(4'd3, 8'h00, "R1 day");
    rd_expect(4'd4, 8'h00, "R1 ctrl");
    rd_expect(4'd8, 8'h00, "R1 stopwatch");

    // R2 busy window, R3 write collides with busy
    next_second();
    check({7'd0, busy}, 8'h01, "R2 busy high");
    do_write(4'd0, 8'h30);
    check({7'd0, busy}, 8'h00, "R2 busy one cycle");
    rd_expect(4'd0, 8'h01, "R3 write in busy ignored");
    do_write(4'd0, 8'h30);
    rd_expect(4'd0, 8'h30, "R3 write outside busy");

    // R4 rollover
    do_write(4'd1, 8'h58);
    do_write(4'd0, 8'h59);
    second();
    rd_expect(4'd0, 8'h00, "R4 sec wrap");
    rd_expect(4'd1, 8'h59, "R4 min carry");

    // R5 illegal digits
    do_write(4'd0, 8'h3C);
    second();
    rd_expect(4'd0, 8'h40, "R5 units fix");
    set_time(8'h05, 8'h10, 8'h69);
    second();
    rd_expect(4'd0, 8'h00, "R5 tens fix");
    rd_expect(4'd1, 8'h11, "R5 tens carry");

    // R6 / R8 24-hour midnight with day wrap
    do_write(4'd3, 8'h06);
    set_time(8'h23, 8'h59, 8'h59);
    second();
    rd_expect(4'd2, 8'h00, "R6 hour wrap");
    rd_expect(4'd3, 8'h00, "R8 day wrap");
    set_time(8'h09, 8'h59, 8'h59);
    second();
    rd_expect(4'd2, 8'h10, "R6 hour tens");

    // R9 / R10 alarm in 24-hour format
    do_write(4'd5, 8'h02);
    do_write(4'd6, 8'h00);
    do_write(4'd7, 8'h10);
    second();
    do_write(4'd9, 8'h02);
    do_write(4'd4, 8'h04);
    check({7'd0, irq}, 8'h00, "R10 irq cleared");
    next_second();
    @(negedge clk);
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R9 no flag before tick");
    run_ticks(1);
    check({7'd0, irq}, 8'h01, "R9 flag on tick");
    rd_expect(4'd9, 8'h02, "R9 status flag");
    do_write(4'd9, 8'h02);
    check({7'd0, irq}, 8'h00, "R10 w1c");

    // R10 set and clear in the same cycle
    do_write(4'd5, 8'h03);
    second();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd9; wr_data = 8'h02;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    sub_cnt = (sub_cnt + 1) % 256;
    check({7'd0, irq}, 8'h01, "R10 set wins");
    do_write(4'd9, 8'h02);

    // R7 12-hour format, interrupt disabled
    do_write(4'd4, 8'h02);
    do_write(4'd3, 8'h03);
    do_write(4'd5, 8'h00);
    do_write(4'd7, 8'h12);
    set_time(8'h51, 8'h59, 8'h59);
    second();
    rd_expect(4'd2, 8'h12, "R7 11pm to 12am");
    rd_expect(4'd3, 8'h04, "R7 day step");
    run_ticks(1);
    check({7'd0, irq}, 8'h00, "R10 irq masked");
    rd_expect(4'd9, 8'h02, "R10 flag while masked");
    do_write(4'd9, 8'h02);
    set_time(8'h11, 8'h59, 8'h59);
    second();
    rd_expect(4'd2, 8'h52, "R7 11am to 12pm");
    rd_expect(4'd3, 8'h04, "R7 no day step at noon");
    run_ticks(1);
    rd_expect(4'd9, 8'h00, "R9 pm mismatch");
    set_time(8'h52, 8'h59, 8'h59);
    second();
    rd_expect(4'd2, 8'h41, "R7 12 to 01");

    // R11 / R12 stopwatch
    do_write(4'd4, 8'h09);
    rd_expect(4'd4, 8'h01, "R13 ctrl clear bit reads 0");
    run_ticks(64);
    @(negedge clk);
    rd_expect(4'd8, sw_model(64), "R11 64 ticks");
    run_ticks(36);
    rd_expect(4'd8, sw_model(100), "R11 100 ticks");
    run_ticks(156);
    rd_expect(4'd8, 8'h00, "R12 wrap at 256");
    run_ticks(26);
    rd_expect(4'd8, sw_model(282), "R11 pattern restart");
    do_write(4'd4, 8'h00);
    run_ticks(50);
    rd_expect(4'd8, sw_model(282), "R12 hold when stopped");
    do_write(4'd4, 8'h08);
    rd_expect(4'd8, 8'h00, "R12 clear");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule